// File: doc/BRIEF.md
# Windowed FIFO Write Controller

This block is the producer-side pointer controller of a FIFO whose storage is an external two-port memory. A producer offers words over a valid/ready handshake. Each accepted word turns into a single-cycle memory write strobe at the current write address, with the word passed straight through to the memory data input. The write pointer is confined to a run-time address window given by a low bound and a high bound. The window size need not be a power of two, so several controllers can carve one memory into separate regions.

An enable input gates every write, which lets an outside arbiter share the memory port. Fullness is found by comparing the slot after the current pointer with the committed read pointer that the read side returns. One slot always stays empty, so a window of N addresses holds N-1 words.

With `COMMIT_EN` set, written words stay invisible to the reader until the producer commits them. The producer can also abort them. A two-state machine tracks this:
- **ST_CLEAN**: the current and committed pointers are equal.
- **ST_PENDING**: uncommitted words exist.

The machine has four transitions:
- **T_WRITE**: ST_CLEAN to ST_PENDING, taken on an accepted write without commit.
- **T_COMMIT**: ST_PENDING to ST_CLEAN, taken on commit.
- **T_ABORT**: ST_PENDING to ST_CLEAN, taken on abort.
- **T_STAY**: any other cycle, in which the state holds.

With `COMMIT_EN` clear, the machine stays in ST_CLEAN and the committed pointer tracks every write.

Top module: `fifo_wr_ctrl`

## Requirements
- R1: A word is accepted in a cycle where `in_valid` and `in_ready` are both 1. In that cycle `mem_we` is 1, `mem_waddr` holds the current pointer and `mem_wdata` equals `in_data`. In every other cycle `mem_we` is 0.
- R2: The current pointer, seen on `mem_waddr`, always lies between `bound_lo` and `bound_hi` inclusive. It advances by one after each accepted word.
- R3: While `enable` is 0, `in_ready` is 0 and no write happens.
- R4: An accepted write at address `bound_hi` moves the pointer to `bound_lo` in the next cycle.
- R5: `in_ready` is 0 when the slot after the current pointer equals `rd_ptr_commit`, so a window holds one word fewer than its number of addresses.
- R6: While `rst_n` is 0, the current and committed pointers both hold `bound_lo`.
- R7: With `COMMIT_EN`=0, `wr_ptr_commit` equals the current pointer in every cycle, and `in_commit` and `in_abort` have no effect.
- R8: With `COMMIT_EN`=1, `wr_ptr_commit` changes only in a cycle with `in_commit`=1 and `in_abort`=0. It then takes the current pointer, including a word written in that same cycle.
- R9: With `COMMIT_EN`=1, `in_abort`=1 forces `in_ready` to 0 and returns the current pointer to `wr_ptr_commit` in the next cycle. Abort wins over a commit in the same cycle.
- R10: With `COMMIT_EN`=1, uncommitted words count toward fullness, because the full test uses the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Write grant from the arbiter |
| bound_lo | input | ADDR_W | First address of the window |
| bound_hi | input | ADDR_W | Last address of the window |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Controller can take a word |
| in_commit | input | 1 | Publish written words to the reader |
| in_abort | input | 1 | Discard uncommitted words |
| in_data | input | DATA_W | Producer word |
| rd_ptr_commit | input | ADDR_W | Committed read pointer from the read side |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W | Memory write address, which is the current pointer |
| mem_wdata | output | DATA_W | Memory write data |
| wr_ptr_commit | output | ADDR_W | Committed write pointer sent to the read side |

## Verification
The bench uses a window of seven addresses that starts away from zero. A design that wraps to address zero, or that advances past `bound_hi`, writes outside its region and so shows a wrong `mem_waddr`. The bench fills the window against a fixed read pointer to catch an off-by-one full test. Such a design would either overwrite the slot the reader still owns or waste one slot. Commit, abort and the two together are driven on top of writes. A committed pointer that misses the same-cycle word, or that lets a commit beat an abort, then diverges from the model. A second instance with commit mode off gets the same commit and abort pulses, to show they change nothing.

// File: rtl/fifo_wr_pkg.sv
package fifo_wr_pkg;
    // Commit tracking state of the write controller
    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_PENDING = 1'b1
    } wr_state_e;
endpackage

// File: rtl/fifo_wr_ptr_step.sv
// Next position of a pointer that walks a [lo, hi] window and wraps to lo.
module fifo_wr_ptr_step #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        if (ptr == hi) nxt = lo;
        else           nxt = ptr + ONE;
    end
endmodule

// File: rtl/fifo_wr_commit_fsm.sv
// Tracks the committed write pointer; the variant is picked by COMMIT_EN.
module fifo_wr_commit_fsm
    import fifo_wr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter bit COMMIT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bound_lo,
    input  logic              accept,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] nxt_ptr,
    input  logic              do_commit,
    input  logic              do_abort,
    output logic [ADDR_W-1:0] com_ptr,
    output wr_state_e         state
);
    wr_state_e         state_nx;
    logic [ADDR_W-1:0] com_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_CLEAN;
            com_ptr <= bound_lo;
        end else begin
            state   <= state_nx;
            com_ptr <= com_nx;
        end
    end

    generate
        if (COMMIT_EN) begin : g_commit
            // Next state and committed pointer with commit/abort
            always_comb begin
                state_nx = state;
                com_nx   = com_ptr;
                unique case (state)
                    ST_CLEAN: begin
                        if (!do_abort && accept && !do_commit)
                            state_nx = ST_PENDING;          // T_WRITE
                    end
                    ST_PENDING: begin
                        if (do_abort)
                            state_nx = ST_CLEAN;            // T_ABORT
                        else if (do_commit)
                            state_nx = ST_CLEAN;            // T_COMMIT
                    end
                    default: state_nx = ST_CLEAN;
                endcase
                if (!do_abort && do_commit)
                    com_nx = accept ? nxt_ptr : cur_ptr;
            end
        end else begin : g_plain
            // Committed pointer simply follows each write
            always_comb begin
                state_nx = ST_CLEAN;
                com_nx   = accept ? nxt_ptr : com_ptr;
            end
        end
    endgenerate
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import fifo_wr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 256,
    parameter bit COMMIT_EN = 1'b1,
    localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] bound_lo,
    input  logic [ADDR_W-1:0] bound_hi,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_commit,
    input  logic              in_abort,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] rd_ptr_commit,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] wr_ptr_commit
);
    logic [ADDR_W-1:0] cur_ptr;
    logic [ADDR_W-1:0] nxt_ptr;
    logic [ADDR_W-1:0] com_ptr;
    logic              full;
    logic              abort_go;
    logic              accept;
    wr_state_e         state;

    fifo_wr_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .ptr (cur_ptr),
        .lo  (bound_lo),
        .hi  (bound_hi),
        .nxt (nxt_ptr)
    );

    fifo_wr_commit_fsm #(.ADDR_W(ADDR_W), .COMMIT_EN(COMMIT_EN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bound_lo  (bound_lo),
        .accept    (accept),
        .cur_ptr   (cur_ptr),
        .nxt_ptr   (nxt_ptr),
        .do_commit (in_commit),
        .do_abort  (abort_go),
        .com_ptr   (com_ptr),
        .state     (state)
    );

    // Output process: handshake and memory side
    always_comb begin
        abort_go      = COMMIT_EN && in_abort;
        full          = (nxt_ptr == rd_ptr_commit);
        in_ready      = enable && !full && !abort_go;
        accept        = in_valid && in_ready;
        mem_we        = accept;
        mem_waddr     = cur_ptr;
        mem_wdata     = in_data;
        wr_ptr_commit = com_ptr;
    end

    // Current pointer register; an abort only rewinds while words are pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_ptr <= bound_lo;
        else if (abort_go && state == ST_PENDING)
            cur_ptr <= com_ptr;
        else if (accept)
            cur_ptr <= nxt_ptr;
    end
endmodule

// File: rtl/fifo_wr_ctrl_chk.sv
module fifo_wr_ctrl_chk #(
    parameter int ADDR_W    = 8,
    parameter bit COMMIT_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [ADDR_W-1:0] bound_lo,
    input logic [ADDR_W-1:0] bound_hi,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_commit,
    input logic              in_abort,
    input logic [ADDR_W-1:0] rd_ptr_commit,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] wr_ptr_commit
);
    AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> in_valid);                                              // R1
    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_waddr >= bound_lo) && (mem_waddr <= bound_hi));               // R2
    AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!in_ready && !mem_we));                               // R3
    AST_WRAP_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_waddr == bound_hi) |=> (mem_waddr == $past(bound_lo))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_waddr == rd_ptr_commit && !in_abort) |=> (mem_waddr != $past(rd_ptr_commit) || !$past(mem_we))); // R5

    generate
        if (COMMIT_EN) begin : g_commit
            AST_COMMIT_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                !(in_commit && !in_abort) |=> $stable(wr_ptr_commit));     // R8
            AST_ABORT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
                in_abort |=> (mem_waddr == $past(wr_ptr_commit)));         // R9
            AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                in_abort |-> !in_ready);                                   // R9
        end else begin : g_plain
            AST_PLAIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_we || in_commit || in_abort) |=> (wr_ptr_commit == mem_waddr)); // R7
        end
    endgenerate
endmodule

bind fifo_wr_ctrl fifo_wr_ctrl_chk #(.ADDR_W(ADDR_W), .COMMIT_EN(COMMIT_EN)) u_chk (.*);

// File: tb/fifo_wr_ctrl_tb.sv
module fifo_wr_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int AW     = 4;
    localparam int LO     = 3;
    localparam int HI     = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [AW-1:0] bound_lo = AW'(LO);
    logic [AW-1:0] bound_hi = AW'(HI);
    logic in_valid = 1'b0, in_commit = 1'b0, in_abort = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [AW-1:0] rd_ptr = AW'(LO);

    logic c_ready, c_we, p_ready, p_we;
    logic [AW-1:0] c_waddr, c_cptr, p_waddr, p_cptr;
    logic [DATA_W-1:0] c_wdata, p_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    int m_cur_c, m_com_c, m_cur_p, m_com_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .COMMIT_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bound_lo(bound_lo), .bound_hi(bound_hi),
        .in_valid(in_valid), .in_ready(c_ready), .in_commit(in_commit), .in_abort(in_abort),
        .in_data(in_data), .rd_ptr_commit(rd_ptr), .mem_we(c_we), .mem_waddr(c_waddr),
        .mem_wdata(c_wdata), .wr_ptr_commit(c_cptr));

    fifo_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .COMMIT_EN(1'b0)) u_dut_plain (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bound_lo(bound_lo), .bound_hi(bound_hi),
        .in_valid(in_valid), .in_ready(p_ready), .in_commit(in_commit), .in_abort(in_abort),
        .in_data(in_data), .rd_ptr_commit(rd_ptr), .mem_we(p_we), .mem_waddr(p_waddr),
        .mem_wdata(p_wdata), .wr_ptr_commit(p_cptr));

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int step(input int p);
        return (p == HI) ? LO : p + 1;
    endfunction

    // One clock: drive inputs after the falling edge, compare, advance the model
    task automatic cyc(input bit en, input bit v, input bit cm, input bit ab,
                       input int rd);
        int nc, np;
        bit rc, rp, ac, ap;
        @(negedge clk);
        enable = en; in_valid = v; in_commit = cm; in_abort = ab;
        in_data = DATA_W'($urandom); rd_ptr = AW'(rd);
        #1;
        nc = step(m_cur_c);
        np = step(m_cur_p);
        rc = en && (nc != rd) && !ab;     // R3 R5 R9 R10
        rp = en && (np != rd);            // R3 R5 R7
        ac = v && rc;
        ap = v && rp;
        chk("R5 ready commit-mode", c_ready, rc);
        chk("R5 ready plain", p_ready, rp);
        chk("R1 we commit-mode", c_we, ac);
        chk("R1 we plain", p_we, ap);
        chk("R2 waddr commit-mode", c_waddr, m_cur_c);
        chk("R2 waddr plain", p_waddr, m_cur_p);
        chk("R1 wdata", c_wdata, in_data);
        chk("R8 committed ptr", c_cptr, m_com_c);
        chk("R7 committed ptr plain", p_cptr, m_com_p);
        if (ab) m_cur_c = m_com_c;
        else begin
            if (ac) m_cur_c = nc;
            if (cm) m_com_c = m_cur_c;
        end
        if (ap) begin m_cur_p = np; m_com_p = np; end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        m_cur_c = LO; m_com_c = LO; m_cur_p = LO; m_com_p = LO;
        repeat (3) @(negedge clk);
        // R6: pointers at the low bound while in reset
        chk("R6 reset waddr", c_waddr, LO);
        chk("R6 reset committed", c_cptr, LO);
        chk("R6 reset plain committed", p_cptr, LO);
        @(negedge clk); rst_n = 1'b1;

        // R3: disabled, no writes
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, LO);
        // R5 R10: fill against a fixed reader, uncommitted words count
        for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, LO);
        // R9: abort rewinds commit-mode pointer; plain ignores it (R7)
        cyc(1'b1, 1'b1, 1'b0, 1'b1, LO);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, LO);   // abort beats commit
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, LO);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, LO);   // R8 commit with same-cycle word
        // R4: reader moves on, writer wraps from HI to LO
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, (i % 4) == 3, 1'b0, 7);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 7);    // R8 commit without a write
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            r = LO + ($urandom % (HI - LO + 1));
            cyc(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 5) == 0,
                ($urandom % 9) == 0, r);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule